// File: doc/BRIEF.md
# Indexed Data Memory Access Window

This block gives a host on a simple valid/ready register bus indirect access to a 64 KiB, byte-addressed data memory. It holds a configurable number of port pairs. Each pair has two registers:

- A pointer register. It holds a word address and two independent auto-advance enables.
- A data register. A host access to it becomes a 32-bit load from, or a 32-bit store to, the memory word the pointer selects.

Several host agents can each own one pair and walk through separate buffers without reloading their pointers. A pair's pointer can step forward on writes only, on reads only, or on both.

The memory is shared with the processor core. The block raises a memory request only when the core is not using the memory. A host data access is therefore stalled, with ready held low, for as long as the core is busy. The number of pairs, 1 or 4, is a parameter and is reported on a capability output.

Top module: `idx_data_port`

## Requirements
- R1: The pointer register of a pair reads back as follows:
  - bits 15:2 are the word address;
  - bit 24 is the write auto-advance enable;
  - bit 25 is the read auto-advance enable;
  - every other bit reads as zero.
- R2: A host write to a data register stores the 32-bit write data at byte address {pointer bits 15:2, 2'b00}. Address bits 1:0 are always zero.
- R3: A host read of a data register returns the 32-bit word at the pointer address. The block issues one memory read request, and ready rises in the cycle after the request.
- R4: When bit 24 is set, every completed data write advances the pointer by 4 bytes after the store. Otherwise the pointer is unchanged.
- R5: When bit 25 is set, every completed data read advances the pointer by 4 bytes after the load. Otherwise the pointer is unchanged.
- R6: Advancing from address 0xFFFC wraps to 0x0000, and bits 24 and 25 are left unchanged.
- R7: Pair i has its pointer register at byte offset 0x1C0+8*i and its data register at 0x1C4+8*i. Offset bits 1:0 are ignored. Pairs hold independent state.
- R8: The parameter NPORTS (1 or 4) sets the pair count, and `cap_ports` equals NPORTS.
- R9: Inside the 0x1C0–0x1DF window, an access to a pair number at or above NPORTS:
  - ignores writes;
  - reads as zero;
  - completes in the cycle it is presented;
  - issues no memory request.
- R10: While `core_busy` is high, a host data access issues no memory request, keeps `h_ready` low, and does not advance its pointer. It completes once `core_busy` falls.
- R11: After reset, every pointer register reads as zero.
- R12: Pointer register accesses, and accesses at offsets outside the window, complete in the cycle they are presented. Outside offsets read as zero and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_valid | input | 1 | Host access request, held until ready |
| h_write | input | 1 | 1 = write, 0 = read |
| h_addr | input | 12 | Host register byte offset |
| h_wdata | input | 32 | Host write data |
| h_ready | output | 1 | Access completes in this cycle |
| h_rdata | output | 32 | Read data, valid while h_ready |
| core_busy | input | 1 | Core owns the memory this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after a read request |
| cap_ports | output | 3 | Number of implemented pairs |

## Verification
Two events can coincide in one cycle: a host data access with auto-advance enabled, and core ownership of the memory. The bench raises `core_busy` before presenting such writes and reads and holds it for several cycles. In every stalled cycle it checks that `mem_req` and `h_ready` are low. Once the core releases the memory, it checks that exactly one store or load took place and that the pointer advanced by exactly one word.

// File: rtl/idx_data_port.sv
module idx_data_port #(
  parameter int NPORTS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        h_valid,
  input  logic        h_write,
  input  logic [11:0] h_addr,
  input  logic [31:0] h_wdata,
  output logic        h_ready,
  output logic [31:0] h_rdata,
  input  logic        core_busy,
  output logic        mem_req,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic [2:0]  cap_ports
);
  localparam int SLOTS = 4;
  localparam int PW    = $clog2(SLOTS);
  localparam int AWW   = 14;

  logic [AWW-1:0] ad  [SLOTS];
  logic           war [SLOTS];
  logic           rar [SLOTS];
  logic           pend;

  logic [PW-1:0] sel;
  logic          in_win, is_dat, live, data_acc;
  logic [31:0]   idx_val;

  assign sel      = h_addr[2+PW:3];
  assign is_dat   = h_addr[2];
  assign in_win   = (h_addr[11:5] == 7'h0E);
  assign live     = in_win && (int'(sel) < NPORTS);
  assign data_acc = h_valid && live && is_dat;

  assign mem_req   = data_acc && !pend && !core_busy;
  assign mem_we    = h_write;
  assign mem_addr  = {ad[sel], 2'b00};
  assign mem_wdata = h_wdata;
  assign cap_ports = 3'(NPORTS);

  assign h_ready = h_valid && (!data_acc || pend || (mem_req && h_write));
  assign idx_val = {6'b0, rar[sel], war[sel], 8'b0, ad[sel], 2'b00};

  always_comb begin
    if (pend)                           h_rdata = mem_rdata;
    else if (live && !is_dat && h_valid) h_rdata = idx_val;
    else                                h_rdata = '0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend <= 1'b0;
    else        pend <= mem_req && !h_write;

  for (genvar p = 0; p < SLOTS; p++) begin : g_pair
    logic mine;
    assign mine = live && (sel == PW'(p)) && h_valid;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        ad[p]  <= '0;
        war[p] <= 1'b0;
        rar[p] <= 1'b0;
      end else if (mine && !is_dat && h_write) begin
        ad[p]  <= h_wdata[15:2];
        war[p] <= h_wdata[24];
        rar[p] <= h_wdata[25];
      end else if (mine && is_dat) begin
        if ((mem_req && h_write && war[p]) || (pend && rar[p]))
          ad[p] <= ad[p] + 1'b1;
      end
  end

  // R3
  rd_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && h_valid) |=> (h_ready && !mem_req));

  // R10
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_busy && data_acc && !pend) |-> (!mem_req && !h_ready));

  // R4
  wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && war[sel]) |=> (ad[$past(sel)] == $past(ad[sel]) + 14'd1));

  // R5
  rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && data_acc && rar[sel]) |=> (ad[$past(sel)] == $past(ad[sel]) + 14'd1));

  // R9
  oor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_valid && in_win && !live) |-> (h_ready && !mem_req && h_rdata == 32'h0));
endmodule

// File: tb/idx_data_port_test.sv
module idx_data_port_test;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic        h_valid = 0, h_write = 0, h_ready, mem_req, mem_we, core_busy = 0;
  logic [11:0] h_addr = '0;
  logic [31:0] h_wdata = '0, h_rdata, mem_wdata, mem_rdata = '0;
  logic [15:0] mem_addr;
  logic [2:0]  cap_ports;

  logic        v1 = 0, w1 = 0, r1_ready, r1_req, r1_we;
  logic [11:0] a1 = '0;
  logic [31:0] d1 = '0, r1_rdata, r1_wd;
  logic [15:0] r1_addr;
  logic [2:0]  r1_cap;
  int          r1_reqs = 0;

  int total = 0, bad = 0;
  logic [31:0] mem [logic [15:0]];

  idx_data_port #(.NPORTS(4)) uut (
    .clk, .rst_n, .h_valid, .h_write, .h_addr, .h_wdata, .h_ready, .h_rdata,
    .core_busy, .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata, .cap_ports);

  idx_data_port #(.NPORTS(1)) uut1 (
    .clk, .rst_n, .h_valid(v1), .h_write(w1), .h_addr(a1), .h_wdata(d1),
    .h_ready(r1_ready), .h_rdata(r1_rdata), .core_busy(1'b0), .mem_req(r1_req),
    .mem_we(r1_we), .mem_addr(r1_addr), .mem_wdata(r1_wd), .mem_rdata(32'h0),
    .cap_ports(r1_cap));

  always @(posedge clk) begin
    if (mem_req && mem_we) mem[mem_addr] = mem_wdata;
    if (mem_req && !mem_we) mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
    if (r1_req) r1_reqs++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit w, input logic [11:0] a, input logic [31:0] d,
                     input int busy, output logic [31:0] rd, output int waits);
    waits = 0;
    @(negedge clk);
    core_busy = (busy > 0);
    h_valid = 1; h_write = w; h_addr = a; h_wdata = d;
    forever begin
      #1;
      if (waits < busy && (mem_req || h_ready)) chk("R10 stall", {mem_req, h_ready}, 2'b00);
      if (h_ready) break;
      @(negedge clk);
      waits++;
      if (waits >= busy) core_busy = 0;
    end
    rd = h_rdata;
    @(negedge clk);
    h_valid = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] x; int n;
    acc(1, a, d, 0, x, n);
  endtask

  function automatic logic [31:0] rd_now(input logic [11:0] a);
    return 32'h0;
  endfunction

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    int n;
    acc(0, a, 32'h0, 0, v, n);
  endtask

  task automatic acc1(input bit w, input logic [11:0] a, input logic [31:0] d, output logic [31:0] v);
    @(negedge clk);
    v1 = 1; w1 = w; a1 = a; d1 = d;
    #1;
    chk("R9 immediate ready", {31'b0, r1_ready}, 32'h1);
    v = r1_rdata;
    @(negedge clk);
    v1 = 0;
  endtask

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;

    for (int p = 0; p < 4; p++) begin
      rd(12'h1C0 + 12'(8*p), v);
      chk("R11 reset pointer", v, 32'h0);
    end
    chk("R8 cap 4", {29'b0, cap_ports}, 32'd4);
    chk("R8 cap 1", {29'b0, r1_cap}, 32'd1);

    for (int p = 0; p < 4; p++) begin
      logic [31:0] pat;
      pat = 32'hA5A5_0000 ^ (32'h1357 * (p + 1)) ^ (32'(p & 3) << 24);
      acc(1, 12'h1C0 + 12'(8*p), pat, 0, v, n);
      chk("R12 pointer write no wait", n, 0);
      rd(12'h1C0 + 12'(8*p) + 12'(p & 3), v);
      chk("R1 R7 pointer readback", v, pat & 32'h0300_FFFC);
    end
    wr(12'h1D8, 32'hFFFF_FFFF);
    rd(12'h1D8, v);
    chk("R1 all ones", v, 32'h0300_FFFC);

    wr(12'h1C0, 32'h0000_0123);
    wr(12'h1C4, 32'hDEAD_BEEF);
    chk("R2 store aligned", mem.exists(16'h0120) ? mem[16'h0120] : 32'hX, 32'hDEAD_BEEF);
    acc(0, 12'h1C4, 0, 0, v, n);
    chk("R3 load", v, 32'hDEAD_BEEF);
    chk("R3 one wait", n, 1);
    rd(12'h1C0, v);
    chk("R4 R5 no advance", v, 32'h0000_0120);

    wr(12'h1C8, 32'h0100_0200);
    for (int k = 0; k < 8; k++) wr(12'h1CC, 32'h1000 + 32'(k * 7));
    rd(12'h1C8, v);
    chk("R4 write advance", v, 32'h0100_0220);
    for (int k = 0; k < 8; k++)
      chk("R4 stored seq", mem.exists(16'(16'h0200 + 4*k)) ? mem[16'(16'h0200 + 4*k)] : 32'hX, 32'h1000 + 32'(k * 7));
    rd(12'h1CC, v);
    rd(12'h1C8, v);
    chk("R4 read does not advance", v, 32'h0100_0220);

    wr(12'h1D0, 32'h0200_0200);
    for (int k = 0; k < 8; k++) begin
      rd(12'h1D4, v);
      chk("R5 read seq", v, 32'h1000 + 32'(k * 7));
    end
    rd(12'h1D0, v);
    chk("R5 read advance", v, 32'h0200_0220);
    wr(12'h1D4, 32'h5555_0000);
    rd(12'h1D0, v);
    chk("R5 write does not advance", v, 32'h0200_0220);
    rd(12'h1C8, v);
    chk("R7 other pair untouched", v, 32'h0100_0220);

    wr(12'h1D8, 32'h0300_FFFC);
    wr(12'h1DC, 32'h7777_8888);
    chk("R6 store at top", mem.exists(16'hFFFC) ? mem[16'hFFFC] : 32'hX, 32'h7777_8888);
    rd(12'h1D8, v);
    chk("R6 wrap", v, 32'h0300_0000);
    wr(12'h1D8, 32'h0300_FFFC);
    rd(12'h1DC, v);
    chk("R6 read at top", v, 32'h7777_8888);
    rd(12'h1D8, v);
    chk("R6 read wrap", v, 32'h0300_0000);

    wr(12'h1C8, 32'h0300_0400);
    acc(1, 12'h1CC, 32'hCAFE_0001, 3, v, n);
    chk("R10 write waited", n, 3);
    chk("R10 stored once", mem.exists(16'h0400) ? mem[16'h0400] : 32'hX, 32'hCAFE_0001);
    chk("R10 no extra store", {31'b0, mem.exists(16'h0404)}, 32'h0);
    acc(0, 12'h1C4, 0, 0, v, n);
    wr(12'h1C0, 32'h0200_0400);
    acc(0, 12'h1C4, 0, 4, v, n);
    chk("R10 read data", v, 32'hCAFE_0001);
    chk("R10 read waited", n, 5);
    rd(12'h1C0, v);
    chk("R10 single advance", v, 32'h0200_0404);
    rd(12'h1C8, v);
    chk("R10 write single advance", v, 32'h0300_0404);

    acc(0, 12'h100, 0, 0, v, n);
    chk("R12 outside reads zero", v, 32'h0);
    chk("R12 outside no wait", n, 0);
    acc(1, 12'h1E0, 32'hFFFF_FFFF, 0, v, n);
    chk("R12 outside write no wait", n, 0);
    rd(12'h1C0, v);
    chk("R12 outside no effect", v, 32'h0200_0404);

    acc1(1, 12'h1C0, 32'h0300_0044, v);
    acc1(0, 12'h1C0, 0, v);
    chk("R8 single pair works", v, 32'h0300_0044);
    acc1(1, 12'h1C8, 32'h0300_0088, v);
    acc1(0, 12'h1C8, 0, v);
    chk("R9 pointer reads zero", v, 32'h0);
    acc1(1, 12'h1DC, 32'h1234_5678, v);
    acc1(0, 12'h1D4, 0, v);
    chk("R9 data reads zero", v, 32'h0);
    chk("R9 no memory request", r1_reqs, 0);
    acc1(0, 12'h1C0, 0, v);
    chk("R9 pair 0 unaffected", v, 32'h0300_0044);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule